// File: doc/BRIEF.md
# Start/Stop Device Control Slave

This block is a slave on a simple shared fetch/store bus. It claims two adjacent bus addresses and uses them to carry commands for a device that can be started, stopped and queried. None of these commands moves data into the device. A store to the base address is the start/stop command: any nonzero value starts the device and zero stops it. A fetch from the address after the base returns a status word. That word holds the run bit, a spin-up busy flag and the raw status lines of the device.

Every request lasts one cycle and is marked as a fetch or a store. The slave answers only requests addressed to one of its two locations, and it answers with a one-cycle ready pulse that carries an error bit. All other addresses belong to other devices or to unused holes, and the slave does not respond to them. A store to the status address never changes device state. A parameter chooses whether that store completes normally or completes with an error. The device itself lies outside the block: it sees only the run output and drives only the status inputs.

Top module: `motor_csr_slave`

## Requirements
- R1: After reset, runOut is 0, rspReady is 0, rspErr is 0 and the busy flag in the status word is 0.
- R2: A store of a nonzero value to BASE_ADDR sets runOut at the clock edge that samples the request. The response to that store has rspErr = 0.
- R3: A store of zero to BASE_ADDR clears runOut and the busy flag at the clock edge that samples the request. The response to that store has rspErr = 0.
- R4: A fetch from BASE_ADDR+1 returns the status word. Bit 0 is the run bit, bit 1 is the busy flag, bits [2 +: STAT_IN_W] are devStatus as sampled with the request, and every other bit is zero.
- R5: A start command issued while stopped sets the busy flag for exactly SPINUP_CYCLES clock edges after the start edge. A fetch sampled at edge SPINUP_CYCLES after the start still reads busy = 1, and a fetch sampled one edge later reads busy = 0. A start command issued while already running does not reload the spin-up count.
- R6: A store to BASE_ADDR+1 changes neither runOut nor the busy flag. Its response has rspErr = 1 when STATUS_WRITE_ERR = 1 and rspErr = 0 when STATUS_WRITE_ERR = 0.
- R7: A fetch from BASE_ADDR returns the run bit in bit 0, with all other bits zero.
- R8: A request to any address other than BASE_ADDR or BASE_ADDR+1 produces no ready pulse, does not change runOut, and leaves rspRdata at zero.
- R9: Each request addressed to the slave produces exactly one rspReady pulse, one cycle after the request. rspErr is never 1 without rspReady, and rspRdata is zero in every cycle that is not a fetch response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqStore | input | 1 | 1 = store, 0 = fetch |
| reqAddr | input | ADDR_W | Bus address |
| reqWdata | input | DATA_W | Store data |
| rspReady | output | 1 | One-cycle response pulse |
| rspErr | output | 1 | Error flag, valid with rspReady |
| rspRdata | output | DATA_W | Fetch data, valid with rspReady |
| runOut | output | 1 | Run command to the device |
| devStatus | input | STAT_IN_W | Raw device status lines |

## Verification
The clock edge that samples a request, E0, updates every result of that request. runOut, rspReady, rspErr and rspRdata all change at E0, so the bench drives each request at a falling edge and reads all outputs at the next falling edge. The spin-up window is counted in edges after the start: the bench places a fetch at edge SPINUP_CYCLES, which must read busy, and another at edge SPINUP_CYCLES+1, which must read idle. A retriggered start is checked against the original schedule. Both error policies are covered by a second instance, with STATUS_WRITE_ERR = 0, that receives the same bus stimulus.

// File: rtl/motor_csr_pkg.sv
package motor_csr_pkg;

  // Per-request strobes from control to datapath
  typedef struct packed {
    logic doStart;   // store nonzero to base
    logic doStop;    // store zero to base
    logic rdRun;     // fetch from base
    logic rdStat;    // fetch from status address
  } csrStrobe_t;

endpackage

// File: rtl/motor_csr_ctrl.sv
module motor_csr_ctrl
  import motor_csr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter bit STATUS_WRITE_ERR = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wdataNonZero,
  output csrStrobe_t        strobe,
  output logic              rspReady,
  output logic              rspErr
);

  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE_ADDR + 1'b1;

  logic hitBase;
  logic hitStat;
  logic respondNext;
  logic errNext;

  always_comb begin
    hitBase = reqValid && (reqAddr == BASE_ADDR);
    hitStat = reqValid && (reqAddr == STAT_ADDR);

    strobe.doStart = hitBase && reqStore && wdataNonZero;
    strobe.doStop  = hitBase && reqStore && !wdataNonZero;
    strobe.rdRun   = hitBase && !reqStore;
    strobe.rdStat  = hitStat && !reqStore;

    respondNext = hitBase || hitStat;
    errNext     = hitStat && reqStore && STATUS_WRITE_ERR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspReady <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspReady <= respondNext;
      rspErr   <= errNext;
    end
  end

  AST_ERR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspReady); // R9

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr != BASE_ADDR && reqAddr != STAT_ADDR) |=> !rspReady); // R8

  AST_STATWR_POLICY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && reqAddr == STAT_ADDR) |=> (rspReady && rspErr == STATUS_WRITE_ERR)); // R6

  AST_BASE_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr == BASE_ADDR) |=> (rspReady && !rspErr)); // R2

endmodule

// File: rtl/motor_csr_dp.sv
module motor_csr_dp
  import motor_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STAT_IN_W = 4,
  parameter int SPINUP_CYCLES = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  csrStrobe_t           strobe,
  input  logic [STAT_IN_W-1:0] devStatus,
  output logic                 runOut,
  output logic [DATA_W-1:0]    rdData
);

  localparam int CNT_W = $clog2(SPINUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] SPIN_LOAD = CNT_W'(SPINUP_CYCLES);

  logic              runQ;
  logic [CNT_W-1:0]  spinCnt;
  logic              busy;
  logic [DATA_W-1:0] statusWord;
  logic [DATA_W-1:0] runWord;

  assign busy   = (spinCnt != '0);
  assign runOut = runQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      spinCnt <= '0;
    end else if (strobe.doStart) begin
      runQ <= 1'b1;
      if (!runQ) spinCnt <= SPIN_LOAD;
      else if (busy) spinCnt <= spinCnt - 1'b1;
    end else if (strobe.doStop) begin
      runQ    <= 1'b0;
      spinCnt <= '0;
    end else if (busy) begin
      spinCnt <= spinCnt - 1'b1;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[0] = runQ;
    statusWord[1] = busy;
    statusWord[2 +: STAT_IN_W] = devStatus;
    runWord = '0;
    runWord[0] = runQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.rdStat) rdData <= statusWord;
    else if (strobe.rdRun)  rdData <= runWord;
    else                    rdData <= '0;
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStart |=> runOut); // R2

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doStop |=> (!runOut && !busy)); // R3

  AST_BUSY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runQ); // R5

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doStart && runQ) |=> (spinCnt <= $past(spinCnt))); // R5

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doStart && !strobe.doStop) |=> $stable(runQ)); // R6

endmodule

// File: rtl/motor_csr_slave.sv
module motor_csr_slave
  import motor_csr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int STAT_IN_W = 4,
  parameter int SPINUP_CYCLES = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0040,
  parameter bit STATUS_WRITE_ERR = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqStore,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  output logic                 rspReady,
  output logic                 rspErr,
  output logic [DATA_W-1:0]    rspRdata,
  output logic                 runOut,
  input  logic [STAT_IN_W-1:0] devStatus
);

  csrStrobe_t strobe;
  logic       wdataNonZero;

  assign wdataNonZero = |reqWdata;

  motor_csr_ctrl #(
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .STATUS_WRITE_ERR(STATUS_WRITE_ERR)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .reqStore(reqStore),
    .reqAddr(reqAddr),
    .wdataNonZero(wdataNonZero),
    .strobe(strobe),
    .rspReady(rspReady),
    .rspErr(rspErr)
  );

  motor_csr_dp #(
    .DATA_W(DATA_W),
    .STAT_IN_W(STAT_IN_W),
    .SPINUP_CYCLES(SPINUP_CYCLES)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .devStatus(devStatus),
    .runOut(runOut),
    .rdData(rspRdata)
  );

  AST_DATA_ONLY_ON_READY: assert property (@(posedge clk) disable iff (!rstN)
    !rspReady |-> (rspRdata == '0)); // R9

endmodule

// File: tb/motor_csr_slave_tb_top.sv
module motor_csr_slave_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam int SPIN = 6;
  localparam logic [AW-1:0] BASE = 16'h0040;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqStore = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [SW-1:0] devStatus = 4'hA;

  logic rspReady, rspErr, runOut;
  logic [DW-1:0] rspRdata;
  logic qReady, qErr, qRun;
  logic [DW-1:0] qRdata;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  logic gReady, gErr, gQReady, gQErr;
  logic [DW-1:0] gData;

  always #10 clk = ~clk;

  motor_csr_slave #(.ADDR_W(AW), .DATA_W(DW), .STAT_IN_W(SW), .SPINUP_CYCLES(SPIN),
    .BASE_ADDR(BASE), .STATUS_WRITE_ERR(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(rspReady), .rspErr(rspErr),
    .rspRdata(rspRdata), .runOut(runOut), .devStatus(devStatus));

  motor_csr_slave #(.ADDR_W(AW), .DATA_W(DW), .STAT_IN_W(SW), .SPINUP_CYCLES(SPIN),
    .BASE_ADDR(BASE), .STATUS_WRITE_ERR(1'b0)) dutQuiet_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspReady(qReady), .rspErr(qErr),
    .rspRdata(qRdata), .runOut(qRun), .devStatus(devStatus));

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] statWord(input bit run, input bit busy,
                                             input logic [SW-1:0] dev);
    logic [DW-1:0] w;
    w = '0;
    w[0] = run;
    w[1] = busy;
    w[2 +: SW] = dev;
    return w;
  endfunction

  // Drive one request for one cycle; sample all results one edge later
  task automatic busReq(input bit store, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    reqValid = 1'b1;
    reqStore = store;
    reqAddr  = addr;
    reqWdata = data;
    @(negedge clk);
    reqValid = 1'b0;
    reqStore = 1'b0;
    reqWdata = '0;
    gReady  = rspReady;
    gErr    = rspErr;
    gData   = rspRdata;
    gQReady = qReady;
    gQErr   = qErr;
  endtask

  task automatic testReset();
    check(runOut == 1'b0, "R1 runOut after reset", DW'(runOut), 0);
    check(rspReady == 1'b0 && rspErr == 1'b0, "R1 response idle after reset",
          DW'({rspReady, rspErr}), 0);
    busReq(1'b0, BASE + 1, '0);
    check(gData == statWord(0, 0, 4'hA), "R1 R4 status after reset", gData, statWord(0, 0, 4'hA));
  endtask

  task automatic testStartStop();
    busReq(1'b1, BASE, 32'h0000_0005);
    check(runOut == 1'b1, "R2 start sets run", DW'(runOut), 1);
    check(gReady && !gErr, "R2 start response", DW'({gReady, gErr}), 32'h2);
    busReq(1'b0, BASE, '0);
    check(gReady && gData == 32'h1, "R7 fetch base while running", gData, 32'h1);
    busReq(1'b1, BASE, 32'h0);
    check(runOut == 1'b0 && gReady && !gErr, "R3 stop clears run", DW'({runOut, gReady, gErr}), 32'h2);
    busReq(1'b0, BASE + 1, '0);
    check(gData == statWord(0, 0, 4'hA), "R3 busy cleared by stop", gData, statWord(0, 0, 4'hA));
    busReq(1'b0, BASE, '0);
    check(gReady && gData == 32'h0, "R7 fetch base while stopped", gData, 32'h0);
  endtask

  task automatic testSpinup();
    busReq(1'b1, BASE, 32'h8000_0000);
    repeat (SPIN - 1) @(negedge clk);
    busReq(1'b0, BASE + 1, '0);
    check(gData == statWord(1, 1, 4'hA), "R5 busy at last spin-up edge", gData, statWord(1, 1, 4'hA));
    busReq(1'b0, BASE + 1, '0);
    check(gData == statWord(1, 0, 4'hA), "R5 idle one edge later", gData, statWord(1, 0, 4'hA));
    busReq(1'b1, BASE, 32'h0);
  endtask

  task automatic testRestart();
    busReq(1'b1, BASE, 32'h1);
    @(negedge clk);
    busReq(1'b1, BASE, 32'h3);
    repeat (SPIN - 3) @(negedge clk);
    busReq(1'b0, BASE + 1, '0);
    check(gData[1] == 1'b1, "R5 busy before original end", DW'(gData[1]), 1);
    busReq(1'b0, BASE + 1, '0);
    check(gData[1] == 1'b0, "R5 restart did not reload", DW'(gData[1]), 0);
    busReq(1'b1, BASE, 32'h0);
  endtask

  task automatic testStatusStore();
    busReq(1'b1, BASE + 1, 32'hFFFF_FFFF);
    check(runOut == 1'b0, "R6 status store does not start", DW'(runOut), 0);
    check(gReady && gErr, "R6 error policy response", DW'({gReady, gErr}), 32'h3);
    check(gQReady && !gQErr, "R6 quiet policy response", DW'({gQReady, gQErr}), 32'h2);
    busReq(1'b1, BASE, 32'h1);
    busReq(1'b1, BASE + 1, 32'h0);
    check(runOut == 1'b1 && qRun == 1'b1, "R6 zero to status does not stop", DW'({runOut, qRun}), 32'h3);
    busReq(1'b0, BASE + 1, '0);
    check(gData == statWord(1, 1, 4'hA), "R6 busy untouched", gData, statWord(1, 1, 4'hA));
    busReq(1'b1, BASE, 32'h0);
  endtask

  task automatic testMiss();
    busReq(1'b1, BASE + 2, 32'h1);
    check(!gReady && runOut == 1'b0, "R8 store above window ignored", DW'({gReady, runOut}), 0);
    busReq(1'b1, BASE - 1, 32'h1);
    check(!gReady && runOut == 1'b0, "R8 store below window ignored", DW'({gReady, runOut}), 0);
    busReq(1'b0, BASE + 2, '0);
    check(!gReady && gData == '0, "R8 fetch miss silent", gData, 0);
  endtask

  task automatic testLayout();
    devStatus = 4'h5;
    busReq(1'b1, BASE, 32'h10);
    busReq(1'b0, BASE + 1, '0);
    check(gData == statWord(1, 1, 4'h5), "R4 layout running busy", gData, statWord(1, 1, 4'h5));
    devStatus = 4'hF;
    busReq(1'b0, BASE + 1, '0);
    check(gData == statWord(1, 1, 4'hF), "R4 devStatus tracked", gData, statWord(1, 1, 4'hF));
    busReq(1'b1, BASE, 32'h0);
    devStatus = 4'hA;
  endtask

  task automatic testPulse();
    busReq(1'b0, BASE + 1, '0);
    check(gReady, "R9 ready on fetch", DW'(gReady), 1);
    @(negedge clk);
    check(!rspReady && !rspErr && rspRdata == '0, "R9 single pulse then idle",
          DW'({rspReady, rspErr}) | rspRdata, 0);
    busReq(1'b1, BASE, 32'h0);
    check(gReady && gData == '0, "R9 no data on store response", gData, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStartStop();
    testSpinup();
    testRestart();
    testStatusStore();
    testMiss();
    testLayout();
    testPulse();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

endmodule